// File: doc/BRIEF.md
# Privileged Trap and Mode Control Unit

This block holds the privileged control state of a simple 32-bit RISC pipeline. It sits beside the core. It takes exception requests, the interrupt lines, access information for the privilege check and the return strobe. It records why and where the flow of control was broken, and it sends fetch to a fixed handler entry point. The block keeps a three-level stack of (user-mode, interrupt-enable) pairs. The stack is pushed when a trap is taken and popped on return, so nested entry and exit need no software help beyond the return strobe.

The core reads and writes the control registers through a small port addressed by a 5-bit register number. The block also checks each memory access the core reports. A user-mode access to the upper half of the address space is turned into an address-error trap. Any user-mode use of the register port is turned into a coprocessor-unusable trap.

The address on `acc_addr` is the one recorded as the bad address. This covers the block's own privilege faults and address or TLB faults that the core reports.

Top module: `cp0_trap_ctrl`

## Requirements
- R1: After reset, Status, Cause, EPC and the bad-address register all read 0. The unit is in kernel mode (`user_mode`=0) with interrupts off (`int_on`=0), and `vec_valid` is 0.
- R2: In the cycle after a trap is taken, `vec_valid` is 1 for exactly one cycle and `vec_pc` is 0x80000080. When `vec_valid` is 0, `vec_pc` is 0.
- R3: The Cause register (number 13) reads as follows. Bit 31 is the delay-slot flag. Bits 29:28 are the coprocessor number of the last trap. Bits 15:8 are the pending interrupts. Bits 6:2 are the trap code. Every other bit reads 0.
- R4: When a trap is taken with `in_delay`=1, EPC (number 14) becomes `fault_pc`-4 and the delay-slot flag becomes 1. Otherwise EPC becomes `fault_pc` and the flag becomes 0. EPC is writable in kernel mode.
- R5: On trap entry, Status bits 5:0 move up by two places and the new bits 1:0 are 00. In each pair the upper bit is user mode (1 = user) and the lower bit is interrupt enable.
- R6: On a return strobe with no trap, Status bits 3:0 take the old value of bits 5:2, and bits 5:4 keep their value.
- R7: The bad-address register (number 8) is loaded from `acc_addr` only by traps with codes 1 to 5. It keeps its value for every other code, including the bus-error codes 6 and 7, and writes to it are ignored.
- R8: In user mode, a reported access with `acc_addr[31]`=1 raises code 5 if it is a store and code 4 if it is a load or fetch. The same access in kernel mode raises nothing, and neither does a user access with bit 31 clear.
- R9: Any use of the register port in user mode raises code 11 with coprocessor number 0. The read returns 0 and the write has no effect.
- R10: An interrupt trap (code 0) is taken when Status bit 0 is 1 and the pending bits ANDed with the Status mask (bits 15:8) are nonzero. Pending bits 9:8 are written through Cause. Pending bits 15:10 follow `ext_irq[5:0]`.
- R11: When several trap sources are active in one cycle, exactly one is recorded, in this order: core request first, then address fault, then register-port violation, then interrupt.
- R12: Writes to Status (number 12) change only bits 31:25, 15:8 and 5:0. All other Status bits read 0.
- R13: Reads of any register number other than 8, 12, 13 or 14 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_exc | input | 1 | Core reports a synchronous trap this cycle |
| core_code | input | 5 | Trap code of the core request |
| core_cop | input | 2 | Coprocessor number of the core request |
| fault_pc | input | 32 | PC of the trapping or interrupted instruction |
| in_delay | input | 1 | That instruction sits in a branch delay slot |
| acc_valid | input | 1 | A memory access or fetch is reported |
| acc_store | input | 1 | The reported access is a store |
| acc_addr | input | 32 | Address of the reported access, also the faulting address |
| ext_irq | input | 6 | External interrupt lines |
| rfe | input | 1 | Return-from-trap strobe |
| reg_en | input | 1 | Register port access this cycle |
| reg_we | input | 1 | Register port access is a write |
| reg_sel | input | 5 | Register number |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| vec_valid | output | 1 | Redirect fetch this cycle |
| vec_pc | output | 32 | Redirect address |
| user_mode | output | 1 | Current user-mode bit |
| int_on | output | 1 | Current interrupt-enable bit |

## Verification
The hardest state to reach is the stack holding three different pairs. A return then lands in user mode, and the next port read would itself trap. The stimulus writes a chosen pattern into Status while still in kernel mode, then steps through trap, return and return, checking the mode outputs rather than reading back. The user-mode privilege faults are then driven from that state. Interrupt priority is reached by holding an enabled line while a core trap clears the enable. The test then checks that nothing is taken until a return restores the enable.

// File: rtl/priv_pkg.sv
package priv_pkg;

    localparam logic [4:0] EXC_INT  = 5'd0;
    localparam logic [4:0] EXC_ADEL = 5'd4;
    localparam logic [4:0] EXC_ADES = 5'd5;
    localparam logic [4:0] EXC_CPU  = 5'd11;

    localparam logic [4:0] RSEL_BADV  = 5'd8;
    localparam logic [4:0] RSEL_STAT  = 5'd12;
    localparam logic [4:0] RSEL_CAUSE = 5'd13;
    localparam logic [4:0] RSEL_EPC   = 5'd14;

    localparam logic [31:0] STAT_WMASK = 32'hFE00_FF3F;

    typedef struct packed {
        logic       valid;
        logic [4:0] code;
        logic [1:0] cop;
    } trap_t;

    function automatic logic is_addr_fault(input logic [4:0] c);
        return (c >= 5'd1) && (c <= 5'd5);
    endfunction

endpackage

// File: rtl/trap_select.sv
module trap_select
    import priv_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  trap_t           cand [NSRC],
    output trap_t           pick,
    output logic [NSRC-1:0] grant
);

    logic [NSRC-1:0] vld;

    for (genvar g = 0; g < NSRC; g++) begin : g_vld
        assign vld[g] = cand[g].valid;
    end

    always_comb begin
        grant = '0;
        pick  = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand[i].valid) begin
                grant    = '0;
                grant[i] = 1'b1;
                pick     = cand[i];
            end
        end
    end

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((|vld) == (|grant))) else $error("grant not single"); // R11
    AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (rst)
        (|vld[NSRC-2:0]) |-> !grant[NSRC-1]) else $error("interrupt beat sync trap"); // R11

endmodule

// File: rtl/mode_stack.sv
module mode_stack
    import priv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  logic        pop,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] stat
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else if (push) begin
            stat[5:0] <= {stat[3:0], 2'b00};
        end else if (pop) begin
            stat[5:0] <= {stat[5:4], stat[5:2]};
        end else if (wr_en) begin
            stat <= wr_data & STAT_WMASK;
        end
    end

    AST_ENTRY_KERNEL: assert property (@(posedge clk) disable iff (rst)
        push |=> stat[1:0] == 2'b00) else $error("entry not kernel"); // R5
    AST_STACK_PUSH: assert property (@(posedge clk) disable iff (rst)
        push |=> stat[5:2] == $past(stat[3:0])) else $error("push lost"); // R5
    AST_STACK_POP: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> (stat[3:0] == $past(stat[5:2])) && (stat[5:4] == $past(stat[5:4])))
        else $error("pop wrong"); // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (stat & ~STAT_WMASK) == 32'd0) else $error("reserved status bit"); // R12

endmodule

// File: rtl/cp0_trap_ctrl.sv
module cp0_trap_ctrl
    import priv_pkg::*;
#(
    parameter logic [31:0] VEC_ADDR = 32'h8000_0080,
    parameter int          N_EXT    = 6,
    parameter int          N_SW     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             core_exc,
    input  logic [4:0]       core_code,
    input  logic [1:0]       core_cop,
    input  logic [31:0]      fault_pc,
    input  logic             in_delay,
    input  logic             acc_valid,
    input  logic             acc_store,
    input  logic [31:0]      acc_addr,
    input  logic [N_EXT-1:0] ext_irq,
    input  logic             rfe,
    input  logic             reg_en,
    input  logic             reg_we,
    input  logic [4:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             vec_valid,
    output logic [31:0]      vec_pc,
    output logic             user_mode,
    output logic             int_on
);

    localparam int NIP  = N_EXT + N_SW;
    localparam int NSRC = 4;

    logic [31:0]     stat;
    logic [31:0]     epc_q, badv_q;
    logic            bd_q;
    logic [1:0]      ce_q;
    logic [4:0]      code_q;
    logic [N_SW-1:0] sw_ip_q;
    logic [NIP-1:0]  ip;
    logic            kernel, irq_hit, take, wr_ok;
    trap_t           cand [NSRC];
    trap_t           pick;
    logic [NSRC-1:0] grant;
    logic [31:0]     cause_rd;

    assign kernel  = !stat[1];
    assign ip      = {ext_irq, sw_ip_q};
    assign irq_hit = stat[0] && |(ip & stat[15:8]);

    always_comb begin
        cand[0] = '{valid: core_exc, code: core_code, cop: core_cop};
        cand[1] = '{valid: acc_valid && !kernel && acc_addr[31],
                    code: acc_store ? EXC_ADES : EXC_ADEL, cop: 2'd0};
        cand[2] = '{valid: reg_en && !kernel, code: EXC_CPU, cop: 2'd0};
        cand[3] = '{valid: irq_hit, code: EXC_INT, cop: 2'd0};
    end

    trap_select #(.NSRC(NSRC)) u_sel (
        .clk   (clk),
        .rst   (rst),
        .cand  (cand),
        .pick  (pick),
        .grant (grant)
    );

    assign take  = pick.valid;
    assign wr_ok = reg_en && reg_we && kernel && !take;

    mode_stack u_stack (
        .clk     (clk),
        .rst     (rst),
        .push    (take),
        .pop     (rfe),
        .wr_en   (wr_ok && (reg_sel == RSEL_STAT)),
        .wr_data (reg_wdata),
        .stat    (stat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q     <= '0;
            badv_q    <= '0;
            bd_q      <= 1'b0;
            ce_q      <= '0;
            code_q    <= '0;
            sw_ip_q   <= '0;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= take;
            if (take) begin
                bd_q   <= in_delay;
                ce_q   <= pick.cop;
                code_q <= pick.code;
                epc_q  <= in_delay ? (fault_pc - 32'd4) : fault_pc;
                if (is_addr_fault(pick.code)) begin
                    badv_q <= acc_addr;
                end
            end else if (wr_ok) begin
                if (reg_sel == RSEL_CAUSE) sw_ip_q <= reg_wdata[8 +: N_SW];
                if (reg_sel == RSEL_EPC)   epc_q   <= reg_wdata;
            end
        end
    end

    always_comb begin
        cause_rd         = '0;
        cause_rd[31]     = bd_q;
        cause_rd[29:28]  = ce_q;
        cause_rd[8 +: NIP] = ip;
        cause_rd[6:2]    = code_q;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_en && kernel) begin
            case (reg_sel)
                RSEL_BADV:  reg_rdata = badv_q;
                RSEL_STAT:  reg_rdata = stat;
                RSEL_CAUSE: reg_rdata = cause_rd;
                RSEL_EPC:   reg_rdata = epc_q;
                default:    reg_rdata = '0;
            endcase
        end
    end

    assign vec_pc    = vec_valid ? VEC_ADDR : '0;
    assign user_mode = stat[1];
    assign int_on    = stat[0];

    AST_REDIRECT_NEXT: assert property (@(posedge clk) disable iff (rst)
        take |=> vec_valid && (vec_pc == VEC_ADDR)) else $error("no redirect"); // R2
    AST_REDIRECT_ONLY: assert property (@(posedge clk) disable iff (rst)
        !take |=> !vec_valid) else $error("spurious redirect"); // R2
    AST_BADV_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(take && is_addr_fault(pick.code)) |=> $stable(badv_q)) else $error("badv moved"); // R7
    AST_USER_NO_RD: assert property (@(posedge clk) disable iff (rst)
        !kernel |-> reg_rdata == 32'd0) else $error("user read leaked"); // R9

endmodule

// File: tb/cp0_trap_ctrl_tb.sv
module cp0_trap_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        core_exc = 0;
    logic [4:0]  core_code = 0;
    logic [1:0]  core_cop = 0;
    logic [31:0] fault_pc = 0;
    logic        in_delay = 0;
    logic        acc_valid = 0;
    logic        acc_store = 0;
    logic [31:0] acc_addr = 0;
    logic [5:0]  ext_irq = 0;
    logic        rfe = 0;
    logic        reg_en = 0;
    logic        reg_we = 0;
    logic [4:0]  reg_sel = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        vec_valid;
    logic [31:0] vec_pc;
    logic        user_mode;
    logic        int_on;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 0;

    cp0_trap_ctrl u_dut (
        .clk(clk), .rst(rst), .core_exc(core_exc), .core_code(core_code),
        .core_cop(core_cop), .fault_pc(fault_pc), .in_delay(in_delay),
        .acc_valid(acc_valid), .acc_store(acc_store), .acc_addr(acc_addr),
        .ext_irq(ext_irq), .rfe(rfe), .reg_en(reg_en), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .vec_valid(vec_valid), .vec_pc(vec_pc), .user_mode(user_mode), .int_on(int_on)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic rd(input logic [4:0] sel, output logic [31:0] d);
        reg_en = 1; reg_we = 0; reg_sel = sel;
        #1 d = reg_rdata;
        reg_en = 0;
    endtask

    task automatic wr(input logic [4:0] sel, input logic [31:0] d);
        reg_en = 1; reg_we = 1; reg_sel = sel; reg_wdata = d;
        step();
        reg_en = 0; reg_we = 0;
    endtask

    task automatic pulse_rfe();
        rfe = 1;
        step();
        rfe = 0;
    endtask

    function automatic logic [31:0] cause_of(input logic bd, input logic [1:0] ce,
                                             input logic [7:0] ipv, input logic [4:0] c);
        return {bd, 1'b0, ce, 12'd0, ipv, 1'b0, c, 2'b00};
    endfunction

    initial begin
        #4_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] bv;
        logic [31:0] pc;
        bv = 0;
        step(); step();
        rst = 0;
        step();

        // R1 reset state
        rd(12, d); chk("R1 status", d, 0);
        rd(13, d); chk("R1 cause", d, 0);
        rd(14, d); chk("R1 epc", d, 0);
        rd(8, d);  chk("R1 badv", d, 0);
        chk("R1 mode", {30'd0, user_mode, int_on}, 0);
        chk("R1 vec_valid", {31'd0, vec_valid}, 0);
        chk("R2 vec_pc idle", vec_pc, 0);

        // R12 status write mask
        wr(12, 32'hFFFF_FFF0);
        rd(12, d); chk("R12 status mask", d, 32'hFE00_FF30);
        // R7 read-only bad address
        wr(8, 32'h1234_5678);
        rd(8, d); chk("R7 badv read-only", d, 0);
        // R10 software pending bits writable, others not
        wr(13, 32'hFFFF_FFFF);
        rd(13, d); chk("R10 sw ip write", d, 32'h0000_0300);
        wr(13, 32'h0);
        // R13 unused numbers
        rd(3, d);  chk("R13 unmapped 3", d, 0);
        rd(31, d); chk("R13 unmapped 31", d, 0);
        wr(14, 32'hCAFE_0000);
        rd(14, d); chk("R4 epc writable", d, 32'hCAFE_0000);

        // sweep of core trap codes and delay-slot flag: R2 R3 R4 R7
        for (int c = 1; c < 16; c++) begin
            for (int ds = 0; ds < 2; ds++) begin
                pc = 32'h0040_0000 + c * 64;
                core_exc = 1; core_code = c[4:0]; core_cop = c[1:0];
                fault_pc = pc; in_delay = ds[0];
                acc_addr = 32'h0100_0000 + c * 4 + ds;
                step();
                core_exc = 0; in_delay = 0;
                if (c <= 5) bv = 32'h0100_0000 + c * 4 + ds;
                chk("R2 vec_valid", {31'd0, vec_valid}, 1);
                chk("R2 vec_pc", vec_pc, 32'h8000_0080);
                rd(13, d); chk("R3 cause", d, cause_of(ds[0], c[1:0], 8'd0, c[4:0]));
                rd(14, d); chk("R4 epc", d, pc - 4 * ds);
                rd(8, d);  chk("R7 badv", d, bv);
                step();
                chk("R2 single cycle", {31'd0, vec_valid}, 0);
            end
        end

        // stack: R5 R6
        wr(12, 32'h0000_000D);
        core_exc = 1; core_code = 8; core_cop = 2; fault_pc = 32'h0000_2000;
        step();
        core_exc = 0;
        rd(12, d); chk("R5 push", d, 32'h0000_0034);
        pulse_rfe();
        rd(12, d); chk("R6 pop", d, 32'h0000_003D);
        pulse_rfe();
        chk("R6 pop to user", {30'd0, user_mode, int_on}, 3);

        // R8 user store to top half
        acc_valid = 1; acc_store = 1; acc_addr = 32'h8000_0010;
        step();
        acc_valid = 0; acc_store = 0;
        chk("R8 store trap", {31'd0, vec_valid}, 1);
        rd(13, d); chk("R8 code 5", d, cause_of(0, 0, 0, 5));
        rd(8, d);  chk("R8 badv store", d, 32'h8000_0010);
        rd(12, d); chk("R5 push user", d, 32'h0000_003C);
        pulse_rfe();
        // R8 user load/fetch
        acc_valid = 1; acc_addr = 32'h9000_0004;
        step();
        acc_valid = 0;
        rd(13, d); chk("R8 code 4", d, cause_of(0, 0, 0, 4));
        rd(8, d);  chk("R8 badv load", d, 32'h9000_0004);
        pulse_rfe();
        // R8 user low half: no trap
        acc_valid = 1; acc_addr = 32'h7FFF_FFFC;
        step();
        acc_valid = 0;
        chk("R8 low half quiet", {30'd0, vec_valid, user_mode}, 1);

        // R9 user register access
        reg_en = 1; reg_we = 1; reg_sel = 12; reg_wdata = 32'h0;
        #1 chk("R9 user read zero", reg_rdata, 0);
        step();
        reg_en = 0; reg_we = 0;
        chk("R9 trap", {31'd0, vec_valid}, 1);
        rd(13, d); chk("R9 code 11 ce 0", d, cause_of(0, 0, 0, 11));
        rd(12, d); chk("R9 write ignored", d, 32'h0000_003C);
        // R8 kernel top half: no trap
        acc_valid = 1; acc_addr = 32'h8000_0000;
        step();
        acc_valid = 0;
        chk("R8 kernel quiet", {31'd0, vec_valid}, 0);

        // R11 priority: core beats address and register faults
        pulse_rfe();
        core_exc = 1; core_code = 12; core_cop = 0;
        acc_valid = 1; acc_store = 1; acc_addr = 32'h8000_0100; reg_en = 1;
        step();
        core_exc = 0; reg_en = 0; acc_valid = 0;
        rd(13, d); chk("R11 core first", d, cause_of(0, 0, 0, 12));
        pulse_rfe();
        acc_valid = 1; acc_store = 1; acc_addr = 32'h8000_0200; reg_en = 1;
        step();
        acc_valid = 0; acc_store = 0; reg_en = 0;
        rd(13, d); chk("R11 address before register", d, cause_of(0, 0, 0, 5));

        // R10 R11 interrupt behind sync trap
        wr(12, 32'h0000_FF01);
        ext_irq = 6'b000001; fault_pc = 32'h0000_3000;
        core_exc = 1; core_code = 12;
        step();
        core_exc = 0;
        rd(13, d); chk("R11 sync before irq", d, cause_of(0, 0, 8'h04, 12));
        rd(12, d); chk("R5 irq disabled", d, 32'h0000_FF04);
        step();
        chk("R10 held while disabled", {31'd0, vec_valid}, 0);
        pulse_rfe();
        step();
        chk("R10 irq taken", {31'd0, vec_valid}, 1);
        rd(13, d); chk("R10 irq cause", d, cause_of(0, 0, 8'h04, 0));
        rd(14, d); chk("R4 irq epc", d, 32'h0000_3000);
        ext_irq = 0;
        // R10 masked software interrupt
        wr(12, 32'h0000_FE01);
        wr(13, 32'h0000_0100);
        step();
        chk("R10 masked quiet", {31'd0, vec_valid}, 0);
        rd(13, d); chk("R10 sw pending", d, cause_of(0, 0, 8'h01, 0));
        wr(12, 32'h0000_FF01);
        step();
        chk("R10 sw irq taken", {31'd0, vec_valid}, 1);
        rd(12, d); chk("R5 sw irq push", d, 32'h0000_FF04);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule